// File: doc/BRIEF.md
# BCD Calendar Clock with Rollover Flag

This block is a real-time clock core that holds the time and date as packed-BCD counters: seconds, minutes, hours, weekday, day of month, month, and a four-digit year split into a century byte and a year-in-century byte. A binary sub-second counter sits below them. It advances once for every pulse on a tick-enable input, which normally arrives 128 times per second. Software reaches the counters and two control registers over a simple register bus. The bus has a halfword index, a write strobe, 16-bit write data and combinational read data.

To set the time, software first writes the second control register with the prescaler-hold bit set and the start bit clear. It then loads the counters. Finally it releases the hold and sets the enable and start bits. A sticky rollover flag is set each time the sub-second counter carries into seconds. Software clears the flag, reads all the counters, and accepts the reading only if the flag is still clear at the end. A 30-second rounding command snaps the seconds to a whole minute. The carry interrupt output is the flag gated by its enable.

Top module: `bcd_rtc_core`

## Requirements
- R1: After an active-low synchronous reset the clock reads 2000, month 01, day 01, weekday 0, 00:00:00, sub-second 0. Both control registers read 0, so the clock is stopped, and carry_irq is 0.
- R2: The register map uses halfword indices. Index 0 holds the sub-second count, which is read-only. Indices 1 through 7 hold seconds, minutes, hours, weekday, day, month and year. Index 14 is control 1 and index 15 is control 2. Any other index reads 0.
- R3: With PRESC_W set to N, the sub-second counter steps on each tick and wraps after 2^N ticks, and that wrap advances the seconds. Counting happens only when three control 2 bits agree: start (bit 0) and enable (bit 3) are both 1, and prescaler-hold (bit 1) is 0.
- R4: While prescaler-hold is 1 the sub-second counter stays at 0.
- R5: Seconds wrap from 59 to 00 and minutes from 59 to 00, both in BCD. Hours wrap from 23 to 00. A wrap carries into the next field.
- R6: Each midnight the day and the weekday both advance, and the weekday wraps from 6 to 0.
- R7: The day wraps to 01 after the last day of the month. April, June, September and November have 30 days, and the other months have 31. February has 29 days when the year-in-century byte is divisible by 4 and 28 otherwise. A day wrap advances the month.
- R8: The month wraps from 12 to 01 and advances the year byte. The year byte wraps from 99 to 00 and advances the century byte. The year reads as a single 16-bit value, {century, year}.
- R9: Control 1 bit 7 is the rollover flag. A seconds carry sets it. A write of 0 to that bit clears it, a write of 1 leaves it unchanged, and a carry in the same cycle as a clearing write wins over the write.
- R10: Control 1 bit 4 is the carry interrupt enable. carry_irq is high exactly when both the flag and the enable are 1.
- R11: A write to control 2 with bit 2 set clears the sub-second counter and sets seconds to 00. If the seconds were 30 or more, the minute also advances, with the normal cascade. Bit 2 always reads back as 0.
- R12: A write to index 1 through 7 loads the written value into that field. Index 7 takes all 16 bits, and the other indices take the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One-cycle sub-second tick enable |
| bus_addr | input | 4 | Halfword register index |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| carry_irq | output | 1 | Rollover interrupt request |

## Verification
The hardest cases to reach are the calendar edges: month ends in leap and non-leap years, the December-to-January year carry, and the century carry. Waiting for these through real counting would take far too long. The bench therefore overrides the prescaler to four ticks per second and loads 23:59:59 on the last day, and on the day before the last, of every month in a leap and a non-leap year. It also steps through every seconds value, both for the normal carry and for the 30-second rounding. The flag race needs one precise cycle, so the bench lines up a clearing write on exactly the tick that wraps the sub-second counter.

// File: rtl/bcd_rtc_pkg.sv
// Shared constants and BCD helper functions for the calendar clock.
// Assumes every BCD operand holds valid digits (0..9 in each nibble).
package bcd_rtc_pkg;

    localparam int IDX_W  = 4;
    localparam int DATA_W = 16;

    localparam logic [IDX_W-1:0] IDX_SUBSEC = 4'd0;
    localparam logic [IDX_W-1:0] IDX_SEC    = 4'd1;
    localparam logic [IDX_W-1:0] IDX_MIN    = 4'd2;
    localparam logic [IDX_W-1:0] IDX_HOUR   = 4'd3;
    localparam logic [IDX_W-1:0] IDX_WDAY   = 4'd4;
    localparam logic [IDX_W-1:0] IDX_DAY    = 4'd5;
    localparam logic [IDX_W-1:0] IDX_MON    = 4'd6;
    localparam logic [IDX_W-1:0] IDX_YEAR   = 4'd7;
    localparam logic [IDX_W-1:0] IDX_CTRL1  = 4'd14;
    localparam logic [IDX_W-1:0] IDX_CTRL2  = 4'd15;

    // Control bit positions
    localparam int C1_FLAG  = 7;
    localparam int C1_IE    = 4;
    localparam int C2_START = 0;
    localparam int C2_HOLD  = 1;
    localparam int C2_ADJ   = 2;
    localparam int C2_EN    = 3;

    // Add one to a two-digit BCD value (no range wrap).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Two-digit BCD year divisible by four.
    function automatic logic bcd_div4(input logic [7:0] y);
        if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    // Last day of a BCD month.
    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
// One packed-BCD calendar field that counts from MIN_VAL up to max_val
// and wraps. The upper limit is an input so the day field can follow the
// month length. A load wins over a zero request, which wins over an increment.
// carry_out flags an increment that wraps this field.
module rtc_bcd_field #(
    parameter logic [7:0] RST_VAL = 8'h00,
    parameter logic [7:0] MIN_VAL = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc,
    input  logic       ld,
    input  logic [7:0] ld_val,
    input  logic       zero,
    input  logic [7:0] max_val,
    output logic [7:0] val,
    output logic       carry_out
);
    import bcd_rtc_pkg::*;

    logic at_top;
    assign at_top    = (val >= max_val);
    assign carry_out = inc && at_top;

    // Field register: load, zero, or step with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)      val <= RST_VAL;
        else if (ld)     val <= ld_val;
        else if (zero)   val <= MIN_VAL;
        else if (inc)    val <= at_top ? MIN_VAL : bcd_inc(val);
    end
endmodule

// File: rtl/rtc_prescaler.sv
// Binary sub-second counter. It steps on each tick while running and
// flags the tick that wraps it. hold forces it to zero.
// Assumes 1 <= W <= 7, so the count fits in the low byte of a register.
module rtc_prescaler #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic         hold,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] LAST = {W{1'b1}};

    assign wrap = run && tick && !hold && (cnt == LAST);

    // Sub-second count: cleared by hold, stepped by tick while running.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (hold)          cnt <= '0;
        else if (run && tick)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rtc_ctrl.sv
// The two control registers: the rollover flag with its interrupt enable,
// and the start, enable and prescaler-hold bits. The rounding command
// leaves as a one-cycle strobe and is never stored.
module rtc_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_c1,
    input  logic       wr_c2,
    input  logic [7:0] wbyte,
    input  logic       sec_carry,
    output logic       start,
    output logic       enable,
    output logic       hold,
    output logic       adj_req,
    output logic       flag,
    output logic       irq_en,
    output logic [7:0] c1_rd,
    output logic [7:0] c2_rd
);
    import bcd_rtc_pkg::*;

    logic unused_wbits;
    assign unused_wbits = ^{wbyte[6:5], wbyte[3:0]} ^ wbyte[C1_IE];

    assign adj_req = wr_c2 && wbyte[C2_ADJ];

    // Rollover flag: set by a carry, cleared only by writing 0; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                          flag <= 1'b0;
        else if (sec_carry)                  flag <= 1'b1;
        else if (wr_c1 && !wbyte[C1_FLAG])   flag <= 1'b0;
    end

    // Interrupt enable and run-control bits, written as plain fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
            start  <= 1'b0;
            enable <= 1'b0;
            hold   <= 1'b0;
        end else begin
            if (wr_c1) irq_en <= wbyte[C1_IE];
            if (wr_c2) begin
                start  <= wbyte[C2_START];
                hold   <= wbyte[C2_HOLD];
                enable <= wbyte[C2_EN];
            end
        end
    end

    // Read-back images of both control registers.
    always_comb begin
        c1_rd          = '0;
        c1_rd[C1_FLAG] = flag;
        c1_rd[C1_IE]   = irq_en;
        c2_rd           = '0;
        c2_rd[C2_START] = start;
        c2_rd[C2_HOLD]  = hold;
        c2_rd[C2_EN]    = enable;
    end
endmodule

// File: rtl/bcd_rtc_core.sv
// Top of the BCD calendar clock. It decodes bus writes, chains the field
// counters (seconds, minutes, hours, then day and weekday, month, year,
// century) and muxes read data. Assumes bus_addr is stable while
// bus_rdata is sampled, since read data is combinational.
module bcd_rtc_core #(
    parameter int PRESC_W = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic [3:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        carry_irq
);
    import bcd_rtc_pkg::*;

    localparam int PAD_W = 8 - PRESC_W;

    logic ctl_start, ctl_en, ctl_hold, ctl_adj, ctl_cf, ctl_cie;
    logic [7:0] c1_rd, c2_rd;
    logic [PRESC_W-1:0] subsec_cnt;
    logic [7:0] subsec_val;
    logic presc_wrap, run;

    logic [7:0] sec_val, min_val, hour_val, wday_val, day_val, mon_val, yr_val, cent_val;
    logic sec_co, min_co, hour_co, wday_co, day_co, mon_co, yr_co, cent_co;
    logic min_inc, leap, unused_co;
    logic [7:0] day_max;

    logic wr_sec, wr_min, wr_hour, wr_wday, wr_day, wr_mon, wr_year, wr_c1, wr_c2;

    // Write decode per register index.
    always_comb begin
        wr_sec  = bus_wr && (bus_addr == IDX_SEC);
        wr_min  = bus_wr && (bus_addr == IDX_MIN);
        wr_hour = bus_wr && (bus_addr == IDX_HOUR);
        wr_wday = bus_wr && (bus_addr == IDX_WDAY);
        wr_day  = bus_wr && (bus_addr == IDX_DAY);
        wr_mon  = bus_wr && (bus_addr == IDX_MON);
        wr_year = bus_wr && (bus_addr == IDX_YEAR);
        wr_c1   = bus_wr && (bus_addr == IDX_CTRL1);
        wr_c2   = bus_wr && (bus_addr == IDX_CTRL2);
    end

    rtc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_c1(wr_c1), .wr_c2(wr_c2),
        .wbyte(bus_wdata[7:0]), .sec_carry(presc_wrap),
        .start(ctl_start), .enable(ctl_en), .hold(ctl_hold), .adj_req(ctl_adj),
        .flag(ctl_cf), .irq_en(ctl_cie), .c1_rd(c1_rd), .c2_rd(c2_rd)
    );

    assign run = ctl_start && ctl_en && !ctl_hold;

    rtc_prescaler #(.W(PRESC_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .run(run),
        .hold(ctl_hold || ctl_adj), .cnt(subsec_cnt), .wrap(presc_wrap)
    );

    assign subsec_val = {{PAD_W{1'b0}}, subsec_cnt};

    // Rounding to a whole minute carries when seconds are 30 or more.
    assign min_inc = sec_co || (ctl_adj && (sec_val >= 8'h30));
    assign leap    = bcd_div4(yr_val);
    assign day_max = month_last(mon_val, leap);

    rtc_bcd_field #(.RST_VAL(8'h00), .MIN_VAL(8'h00)) u_sec (
        .clk(clk), .rst_n(rst_n), .inc(presc_wrap), .ld(wr_sec), .ld_val(bus_wdata[7:0]),
        .zero(ctl_adj), .max_val(8'h59), .val(sec_val), .carry_out(sec_co));

    rtc_bcd_field #(.RST_VAL(8'h00), .MIN_VAL(8'h00)) u_min (
        .clk(clk), .rst_n(rst_n), .inc(min_inc), .ld(wr_min), .ld_val(bus_wdata[7:0]),
        .zero(1'b0), .max_val(8'h59), .val(min_val), .carry_out(min_co));

    rtc_bcd_field #(.RST_VAL(8'h00), .MIN_VAL(8'h00)) u_hour (
        .clk(clk), .rst_n(rst_n), .inc(min_co), .ld(wr_hour), .ld_val(bus_wdata[7:0]),
        .zero(1'b0), .max_val(8'h23), .val(hour_val), .carry_out(hour_co));

    rtc_bcd_field #(.RST_VAL(8'h00), .MIN_VAL(8'h00)) u_wday (
        .clk(clk), .rst_n(rst_n), .inc(hour_co), .ld(wr_wday), .ld_val(bus_wdata[7:0]),
        .zero(1'b0), .max_val(8'h06), .val(wday_val), .carry_out(wday_co));

    rtc_bcd_field #(.RST_VAL(8'h01), .MIN_VAL(8'h01)) u_day (
        .clk(clk), .rst_n(rst_n), .inc(hour_co), .ld(wr_day), .ld_val(bus_wdata[7:0]),
        .zero(1'b0), .max_val(day_max), .val(day_val), .carry_out(day_co));

    rtc_bcd_field #(.RST_VAL(8'h01), .MIN_VAL(8'h01)) u_mon (
        .clk(clk), .rst_n(rst_n), .inc(day_co), .ld(wr_mon), .ld_val(bus_wdata[7:0]),
        .zero(1'b0), .max_val(8'h12), .val(mon_val), .carry_out(mon_co));

    rtc_bcd_field #(.RST_VAL(8'h00), .MIN_VAL(8'h00)) u_year (
        .clk(clk), .rst_n(rst_n), .inc(mon_co), .ld(wr_year), .ld_val(bus_wdata[7:0]),
        .zero(1'b0), .max_val(8'h99), .val(yr_val), .carry_out(yr_co));

    rtc_bcd_field #(.RST_VAL(8'h20), .MIN_VAL(8'h00)) u_cent (
        .clk(clk), .rst_n(rst_n), .inc(yr_co), .ld(wr_year), .ld_val(bus_wdata[15:8]),
        .zero(1'b0), .max_val(8'h99), .val(cent_val), .carry_out(cent_co));

    assign unused_co = wday_co ^ cent_co;

    // Read mux by halfword index; unmapped indices read zero.
    always_comb begin
        case (bus_addr)
            IDX_SUBSEC: bus_rdata = {8'h00, subsec_val};
            IDX_SEC:    bus_rdata = {8'h00, sec_val};
            IDX_MIN:    bus_rdata = {8'h00, min_val};
            IDX_HOUR:   bus_rdata = {8'h00, hour_val};
            IDX_WDAY:   bus_rdata = {8'h00, wday_val};
            IDX_DAY:    bus_rdata = {8'h00, day_val};
            IDX_MON:    bus_rdata = {8'h00, mon_val};
            IDX_YEAR:   bus_rdata = {cent_val, yr_val};
            IDX_CTRL1:  bus_rdata = {8'h00, c1_rd};
            IDX_CTRL2:  bus_rdata = {8'h00, c2_rd};
            default:    bus_rdata = 16'h0000;
        endcase
    end

    assign carry_irq = ctl_cf && ctl_cie;
endmodule

// File: rtl/bcd_rtc_core_checker.sv
// Temporal checks on the calendar clock, bound to the top module.
// Assumes software writes only valid BCD values to the fields.
module bcd_rtc_core_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [3:0] bus_addr,
    input logic       wd_flag_bit,
    input logic       carry_irq,
    input logic       start_q,
    input logic       cf_q,
    input logic       cie_q,
    input logic [7:0] subsec_q,
    input logic [7:0] sec_q,
    input logic [7:0] min_q,
    input logic [7:0] hr_q,
    input logic [7:0] mon_q
);
    assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_q && !bus_wr) |=> ($stable(sec_q) && $stable(min_q) && $stable(hr_q)));

    assert_sec_bcd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q[3:0] <= 4'd9) && (sec_q <= 8'h59));

    assert_month_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_q >= 8'h01) && (mon_q <= 8'h12));

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cf_q && !(bus_wr && (bus_addr == 4'd14) && !wd_flag_bit)) |=> cf_q);

    assert_flag_on_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cf_q) |-> (subsec_q == 8'h00));

    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        carry_irq |-> cie_q);
endmodule

bind bcd_rtc_core bcd_rtc_core_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .wd_flag_bit(bus_wdata[7]), .carry_irq(carry_irq), .start_q(ctl_start),
    .cf_q(ctl_cf), .cie_q(ctl_cie), .subsec_q(subsec_val), .sec_q(sec_val),
    .min_q(min_val), .hr_q(hour_val), .mon_q(mon_val)
);

// File: tb/bcd_rtc_core_test.sv
// Sweep bench: four ticks per second, calendar edges loaded directly.
module bcd_rtc_core_test;
    localparam int PW = 2;
    localparam int TPS = 1 << PW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic [3:0] bus_addr = '0;
    logic bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic carry_irq;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    bcd_rtc_core #(.PRESC_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .carry_irq(carry_irq));

    always #10 clk = ~clk;

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [15:0] bcd_year(input int y);
        return {bcd(y / 100), bcd(y % 100)};
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return ((y % 4) == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #2;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
        end
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic set_time(input int y, input int mo, input int d, input int wd,
                            input int h, input int mi, input int s);
        wr(4'd15, 16'h0002);
        wr(4'd1, {8'h00, bcd(s)});
        wr(4'd2, {8'h00, bcd(mi)});
        wr(4'd3, {8'h00, bcd(h)});
        wr(4'd4, {8'h00, bcd(wd)});
        wr(4'd5, {8'h00, bcd(d)});
        wr(4'd6, {8'h00, bcd(mo)});
        wr(4'd7, bcd_year(y));
        wr(4'd15, 16'h0009);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R2 map
        rd(4'd0, v); check("R1 subsec", v, 16'h0000);
        rd(4'd1, v); check("R1 sec", v, 16'h0000);
        rd(4'd3, v); check("R1 hour", v, 16'h0000);
        rd(4'd4, v); check("R1 wday", v, 16'h0000);
        rd(4'd5, v); check("R1 day", v, 16'h0001);
        rd(4'd6, v); check("R1 month", v, 16'h0001);
        rd(4'd7, v); check("R1 year", v, 16'h2000);
        rd(4'd14, v); check("R1 ctrl1", v, 16'h0000);
        rd(4'd15, v); check("R1 ctrl2", v, 16'h0000);
        check("R1 irq", {15'd0, carry_irq}, 16'h0000);
        ticks(10);
        rd(4'd1, v); check("R1 stopped after reset", v, 16'h0000);
        rd(4'd9, v); check("R2 unmapped index", v, 16'h0000);

        // R12 load, R2 subsec read-only
        set_time(2031, 7, 15, 3, 10, 20, 30);
        rd(4'd2, v); check("R12 minute load", v, 16'h0020);
        rd(4'd7, v); check("R12 year load 16-bit", v, 16'h2031);
        wr(4'd0, 16'h0003);
        rd(4'd0, v); check("R2 subsec read-only", v, 16'h0000);

        // R3 sub-second count and seconds advance
        ticks(TPS - 1);
        rd(4'd0, v); check("R3 subsec count", v, 16'(TPS - 1));
        rd(4'd1, v); check("R3 no early second", v, 16'h0030);
        ticks(1);
        rd(4'd0, v); check("R3 subsec wrap", v, 16'h0000);
        rd(4'd1, v); check("R3 second advance", v, 16'h0031);

        // R3 gating by start and enable
        wr(4'd15, 16'h0008);
        ticks(3 * TPS);
        rd(4'd1, v); check("R3 start low holds", v, 16'h0031);
        wr(4'd15, 16'h0001);
        ticks(3 * TPS);
        rd(4'd1, v); check("R3 enable low holds", v, 16'h0031);

        // R4 prescaler hold
        wr(4'd15, 16'h000B);
        ticks(3 * TPS);
        rd(4'd0, v); check("R4 subsec held", v, 16'h0000);
        rd(4'd1, v); check("R4 seconds held", v, 16'h0031);
        rd(4'd15, v); check("R2 ctrl2 readback", v, 16'h000B);

        // R5 seconds sweep with minute carry
        for (int s = 0; s < 60; s++) begin
            set_time(2030, 5, 10, 2, 12, 34, s);
            ticks(TPS);
            rd(4'd1, v); check("R5 seconds step", v, {8'h00, bcd((s + 1) % 60)});
            rd(4'd2, v); check("R5 minute carry", v, {8'h00, bcd(s == 59 ? 35 : 34)});
        end

        // R6 R7 R8 month ends in leap and non-leap years
        for (int yi = 0; yi < 2; yi++) begin
            for (int m = 1; m <= 12; m++) begin
                for (int last = 0; last < 2; last++) begin
                    int y, d, nd, nm, ny;
                    y = (yi == 0) ? 2023 : 2024;
                    d = last ? mdays(m, y) : mdays(m, y) - 1;
                    nd = last ? 1 : d + 1;
                    nm = (last && m == 12) ? 1 : (last ? m + 1 : m);
                    ny = (last && m == 12) ? y + 1 : y;
                    set_time(y, m, d, m % 7, 23, 59, 59);
                    ticks(TPS);
                    rd(4'd3, v); check("R5 hour wrap", v, 16'h0000);
                    rd(4'd4, v); check("R6 weekday step", v, {8'h00, bcd(((m % 7) + 1) % 7)});
                    rd(4'd5, v); check("R7 day wrap", v, {8'h00, bcd(nd)});
                    rd(4'd6, v); check("R8 month step", v, {8'h00, bcd(nm)});
                    rd(4'd7, v); check("R8 year step", v, bcd_year(ny));
                end
            end
        end

        // R8 century carry at year 99
        set_time(2099, 12, 31, 6, 23, 59, 59);
        ticks(TPS);
        rd(4'd7, v); check("R8 century carry", v, 16'h2100);
        rd(4'd4, v); check("R6 weekday 6 to 0", v, 16'h0000);

        // R9 R10 rollover flag and interrupt
        rd(4'd14, v); check("R9 flag set by carry", v, 16'h0080);
        check("R10 irq off without enable", {15'd0, carry_irq}, 16'h0000);
        wr(4'd14, 16'h0080);
        rd(4'd14, v); check("R9 write 1 keeps flag", v, 16'h0080);
        wr(4'd14, 16'h0090);
        check("R10 irq with enable", {15'd0, carry_irq}, 16'h0001);
        wr(4'd14, 16'h0010);
        rd(4'd14, v); check("R9 write 0 clears", v, 16'h0010);
        check("R10 irq drops with flag", {15'd0, carry_irq}, 16'h0000);

        // R9 set wins over a same-cycle clear
        set_time(2040, 3, 3, 1, 1, 1, 1);
        wr(4'd14, 16'h0010);
        ticks(TPS - 1);
        @(negedge clk);
        tick_en = 1'b1; bus_addr = 4'd14; bus_wdata = 16'h0010; bus_wr = 1'b1;
        @(negedge clk);
        tick_en = 1'b0; bus_wr = 1'b0;
        rd(4'd14, v); check("R9 set wins over clear", v, 16'h0090);
        check("R10 irq after race", {15'd0, carry_irq}, 16'h0001);
        wr(4'd14, 16'h0000);

        // R11 rounding sweep
        for (int s = 0; s < 60; s++) begin
            set_time(2030, 5, 10, 2, 12, 34, s);
            ticks(TPS / 2);
            wr(4'd15, 16'h000D);
            rd(4'd1, v); check("R11 seconds zeroed", v, 16'h0000);
            rd(4'd2, v); check("R11 minute rounding", v, {8'h00, bcd(s >= 30 ? 35 : 34)});
            rd(4'd0, v); check("R11 subsec cleared", v, 16'h0000);
        end
        rd(4'd15, v); check("R11 adjust bit not stored", v, 16'h0009);

        // R11 rounding cascade through the century
        set_time(2099, 12, 31, 4, 23, 59, 45);
        wr(4'd15, 16'h000D);
        rd(4'd7, v); check("R11 cascade year", v, 16'h2100);
        rd(4'd5, v); check("R11 cascade day", v, 16'h0001);
        rd(4'd3, v); check("R11 cascade hour", v, 16'h0000);

        done = 1;
        finish_run();
    end
endmodule